// File: doc/BRIEF.md
# Random Generator Control Register File

This block is the register front end of a hardware random number generator. Software reaches it through a plain 32-bit register bus with an address, a write enable, write data and combinational read data. It keeps the generator's enable, its interrupt enable, the entropy-source selection fields, the sampling clock divider exponent and the clock-check control. Only a write that also raises the reload bit can change the source fields. After such a write, software lowers the reload bit, and the block then runs a fixed-length internal reset cycle. During that cycle the generator is held idle and the reload bit still reads as 1.

The block also tracks error events from the generator core. A seed error raises a sticky interrupt flag and a current-state bit. The core can recover on its own, which clears the state bit and leaves the flag set. Clock errors are recorded only while clock checking is on. The flags are cleared by writing zeros to them, and the interrupt line is the OR of the flags, gated by the interrupt enable. There are also a noise-source control register, a health-test register, a data window onto the core's output word and a read-only revision register.

Top module: `rng_ctrl_regs`

## Requirements
- R1: After reset, the control, status, noise-control and health registers read 0, `irq` is 0 and `core_run` is 0.
- R2: A control write (offset 0x000) with bit 30 set loads the source and clock fields from the written word and drives them to the core: clock-check bit 5, field A bits 11:8, standard-mode bit 12, field B bits 15:13, divider exponent bits 19:16, field C bits 25:20. `core_src` is {C, B, standard-mode, A}.
- R3: A control write with bit 30 clear leaves all fields of R2 unchanged. Every control write updates the run enable (bit 2) and the interrupt enable (bit 3).
- R4: Control bit 30 reads 1 from the write that sets it. If it is then written 0, it keeps reading 1 for RELOAD_CYCLES (16) clock edges after that write, and then reads 0.
- R5: `core_run` is the run enable, forced low while control bit 30 reads 1.
- R6: A `core_seed_err` pulse sets status bit 6 (seed flag) and status bit 2 (seed state). A `core_seed_recover` pulse clears bit 2 and leaves bit 6 set.
- R7: The end of the reload cycle of R4 clears status bit 2 and leaves bit 6 set.
- R8: While control bit 5 is 1, a high `core_clk_err` sets status bit 5 (clock flag), and status bit 1 follows `core_clk_err`. While bit 5 is 0, `core_clk_err` changes neither bit.
- R9: A status write (offset 0x004) clears flag bits 5 and 6 where the written bit is 0 and keeps them where it is 1. A status write of all zeros also clears bit 2.
- R10: `irq` is high exactly when the interrupt enable is set and status bit 5 or bit 6 is set.
- R11: Status bit 0 is 1 when `core_word_vld` is high, `core_run` is high and status bit 2 is clear. Offset 0x008 reads `core_word` when bit 0 is 1, otherwise 0.
- R12: The noise-control register (0x00C) stores bits 17:0 and reads 0 above them. The health register (0x010) stores all 32 bits. Both drive their core outputs.
- R13: The revision register (0x3F4) reads VER_MAJOR in bits 7:4 and VER_MINOR in bits 3:0, with defaults 3 and 1.
- R14: Undefined offsets read 0 and ignore writes. Unimplemented bits of every register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| core_run | output | 1 | Generator enable |
| core_div | output | 4 | Sampling clock divider exponent |
| core_clk_chk | output | 1 | Clock-error checking on |
| core_src | output | 14 | Entropy source selection {C, B, standard-mode, A} |
| core_noise_ctl | output | 18 | Noise-source control value |
| core_health | output | 32 | Health-test control value |
| core_word | input | 32 | Output word from the generator |
| core_word_vld | input | 1 | `core_word` is valid |
| core_seed_err | input | 1 | Seed error event |
| core_seed_recover | input | 1 | Automatic seed recovery event |
| core_clk_err | input | 1 | Clock error condition |

## Verification
The assertions assume that the core's event inputs are single-cycle samples on the same clock. They also assume that a write and an event landing on the same edge resolve with the event winning. The bench drives every event and bus access half a cycle away from the active edge and holds each event for exactly one cycle. It lowers `core_clk_err` before the status write that clears the clock flag, so no check depends on a set and a clear colliding. The random phase touches only the control, noise and health registers. Reloads that it starts by chance affect only `core_run`, which that phase does not check.

// File: rtl/rng_regs_pkg.sv
package rng_regs_pkg;

    localparam int OFF_CTL    = 32'h000;
    localparam int OFF_STAT   = 32'h004;
    localparam int OFF_DATA   = 32'h008;
    localparam int OFF_NOISE  = 32'h00C;
    localparam int OFF_HEALTH = 32'h010;
    localparam int OFF_VER    = 32'h3F4;

    localparam int B_RUN    = 2;
    localparam int B_IRQEN  = 3;
    localparam int B_CLKCHK = 5;
    localparam int B_RELOAD = 30;

    localparam int S_RDY    = 0;
    localparam int S_CLKST  = 1;
    localparam int S_SEEDST = 2;
    localparam int S_CLKFL  = 5;
    localparam int S_SEEDFL = 6;

    localparam int NOISE_W = 18;

    typedef struct packed {
        logic [5:0] src_c;
        logic [3:0] div_exp;
        logic [2:0] src_b;
        logic       std_mode;
        logic [3:0] src_a;
        logic       clk_chk;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTL, SEL_STAT, SEL_DATA, SEL_NOISE, SEL_HEALTH, SEL_VER
    } sel_e;

    function automatic sel_e decode(input logic [31:0] a);
        case (a)
            OFF_CTL:    return SEL_CTL;
            OFF_STAT:   return SEL_STAT;
            OFF_DATA:   return SEL_DATA;
            OFF_NOISE:  return SEL_NOISE;
            OFF_HEALTH: return SEL_HEALTH;
            OFF_VER:    return SEL_VER;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] ctl_word(input cfg_t c, input logic run,
                                             input logic irqen, input logic reload);
        logic [31:0] w;
        w = '0;
        w[B_RUN]    = run;
        w[B_IRQEN]  = irqen;
        w[B_CLKCHK] = c.clk_chk;
        w[11:8]     = c.src_a;
        w[12]       = c.std_mode;
        w[15:13]    = c.src_b;
        w[19:16]    = c.div_exp;
        w[25:20]    = c.src_c;
        w[B_RELOAD] = reload;
        return w;
    endfunction

endpackage

// File: rtl/rng_reload_seq.sv
module rng_reload_seq #(
    parameter int RELOAD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_ctl,
    input  logic wr_reload,
    output logic active,
    output logic done
);
    localparam int CNT_W = $clog2(RELOAD_CYCLES + 1);

    logic             pend;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             start;

    assign start  = wr_ctl && !wr_reload && pend;
    assign active = pend || busy;
    assign done   = busy && (cnt == '0) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
            if (wr_ctl && wr_reload) begin
                pend <= 1'b1;
            end else if (start) begin
                pend <= 1'b0;
                busy <= 1'b1;
                cnt  <= CNT_W'(RELOAD_CYCLES - 1);
            end
        end
    end

    // R4: lowering a set reload bit starts the internal cycle
    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && active);

    // R4: the cycle does not end before its count runs out
    p_len_r4: assert property (@(posedge clk) disable iff (rst)
        busy && (cnt != '0) |=> active);

endmodule

// File: rtl/rng_err_status.sv
module rng_err_status (
    input  logic clk,
    input  logic rst,
    input  logic clk_chk,
    input  logic seed_err,
    input  logic seed_recover,
    input  logic clk_err,
    input  logic reload_done,
    input  logic wr_stat,
    input  logic wr_zero,
    input  logic keep_clk,
    input  logic keep_seed,
    output logic flag_seed,
    output logic flag_clk,
    output logic seed_state,
    output logic clk_state
);
    logic clk_evt;

    assign clk_evt   = clk_err && clk_chk;
    assign clk_state = clk_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_seed  <= 1'b0;
            flag_clk   <= 1'b0;
            seed_state <= 1'b0;
        end else begin
            if (seed_err)                       flag_seed <= 1'b1;
            else if (wr_stat && !keep_seed)     flag_seed <= 1'b0;

            if (clk_evt)                        flag_clk <= 1'b1;
            else if (wr_stat && !keep_clk)      flag_clk <= 1'b0;

            if (seed_err)
                seed_state <= 1'b1;
            else if (seed_recover || reload_done || (wr_stat && wr_zero))
                seed_state <= 1'b0;
        end
    end

    // R6: a seed error raises both flag and state
    p_seed_set_r6: assert property (@(posedge clk) disable iff (rst)
        seed_err |=> flag_seed && seed_state);

    // R7: end of the reload cycle drops the seed state
    p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
        reload_done && !seed_err |=> !seed_state);

    // R8: with checking off no clock flag appears
    p_clk_ign_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_chk && !flag_clk |=> !flag_clk);

endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
    import rng_regs_pkg::*;
#(
    parameter int         ADDR_W        = 12,
    parameter int         RELOAD_CYCLES = 16,
    parameter logic [3:0] VER_MAJOR     = 4'd3,
    parameter logic [3:0] VER_MINOR     = 4'd1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq,
    output logic                core_run,
    output logic [3:0]          core_div,
    output logic                core_clk_chk,
    output logic [13:0]         core_src,
    output logic [NOISE_W-1:0]  core_noise_ctl,
    output logic [31:0]         core_health,
    input  logic [31:0]         core_word,
    input  logic                core_word_vld,
    input  logic                core_seed_err,
    input  logic                core_seed_recover,
    input  logic                core_clk_err
);
    sel_e               sel;
    cfg_t               cfg;
    logic               run_en;
    logic               irq_en;
    logic [NOISE_W-1:0] noise_q;
    logic [31:0]        health_q;
    logic               reload_active;
    logic               reload_done;
    logic               flag_seed, flag_clk, seed_state, clk_state;
    logic               rdy;
    logic               wr_ctl, wr_stat;

    assign sel     = decode(32'(bus_addr));
    assign wr_ctl  = bus_we && (sel == SEL_CTL);
    assign wr_stat = bus_we && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            run_en   <= 1'b0;
            irq_en   <= 1'b0;
            noise_q  <= '0;
            health_q <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_CTL: begin
                    run_en <= bus_wdata[B_RUN];
                    irq_en <= bus_wdata[B_IRQEN];
                    if (bus_wdata[B_RELOAD]) begin
                        cfg.clk_chk  <= bus_wdata[B_CLKCHK];
                        cfg.src_a    <= bus_wdata[11:8];
                        cfg.std_mode <= bus_wdata[12];
                        cfg.src_b    <= bus_wdata[15:13];
                        cfg.div_exp  <= bus_wdata[19:16];
                        cfg.src_c    <= bus_wdata[25:20];
                    end
                end
                SEL_NOISE:  noise_q  <= bus_wdata[NOISE_W-1:0];
                SEL_HEALTH: health_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    rng_reload_seq #(.RELOAD_CYCLES(RELOAD_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_ctl    (wr_ctl),
        .wr_reload (bus_wdata[B_RELOAD]),
        .active    (reload_active),
        .done      (reload_done)
    );

    rng_err_status u_err (
        .clk          (clk),
        .rst          (rst),
        .clk_chk      (cfg.clk_chk),
        .seed_err     (core_seed_err),
        .seed_recover (core_seed_recover),
        .clk_err      (core_clk_err),
        .reload_done  (reload_done),
        .wr_stat      (wr_stat),
        .wr_zero      (bus_wdata == 32'h0),
        .keep_clk     (bus_wdata[S_CLKFL]),
        .keep_seed    (bus_wdata[S_SEEDFL]),
        .flag_seed    (flag_seed),
        .flag_clk     (flag_clk),
        .seed_state   (seed_state),
        .clk_state    (clk_state)
    );

    assign core_run       = run_en && !reload_active;
    assign core_div       = cfg.div_exp;
    assign core_clk_chk   = cfg.clk_chk;
    assign core_src       = {cfg.src_c, cfg.src_b, cfg.std_mode, cfg.src_a};
    assign core_noise_ctl = noise_q;
    assign core_health    = health_q;
    assign irq            = irq_en && (flag_seed || flag_clk);
    assign rdy            = core_word_vld && core_run && !seed_state;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTL:    bus_rdata = ctl_word(cfg, run_en, irq_en, reload_active);
            SEL_STAT: begin
                bus_rdata[S_RDY]    = rdy;
                bus_rdata[S_CLKST]  = clk_state;
                bus_rdata[S_SEEDST] = seed_state;
                bus_rdata[S_CLKFL]  = flag_clk;
                bus_rdata[S_SEEDFL] = flag_seed;
            end
            SEL_DATA:   bus_rdata = rdy ? core_word : 32'h0;
            SEL_NOISE:  bus_rdata[NOISE_W-1:0] = noise_q;
            SEL_HEALTH: bus_rdata = health_q;
            SEL_VER:    bus_rdata[7:0] = {VER_MAJOR, VER_MINOR};
            default:    bus_rdata = '0;
        endcase
    end

    // R3: a control write without the reload bit keeps the configuration
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ctl && !bus_wdata[B_RELOAD]
        |=> $stable(core_src) && $stable(core_div) && $stable(core_clk_chk));

    // R5: raising the reload bit stops the generator
    p_run_low_r5: assert property (@(posedge clk) disable iff (rst)
        wr_ctl && bus_wdata[B_RELOAD] |=> !core_run);

    // R14: writes to undefined offsets change nothing
    p_undef_r14: assert property (@(posedge clk) disable iff (rst)
        bus_we && (sel == SEL_NONE)
        |=> $stable(core_noise_ctl) && $stable(core_health) && $stable(core_src));

endmodule

// File: tb/rng_ctrl_regs_tb.sv
`timescale 1ns/100ps
module rng_ctrl_regs_tb;
    localparam logic [11:0] A_CTL = 12'h000, A_STAT = 12'h004, A_DATA = 12'h008,
                            A_NOISE = 12'h00C, A_HEALTH = 12'h010, A_VER = 12'h3F4;
    localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;
    localparam logic [31:0] RELOAD   = 32'h4000_0000;
    localparam logic [31:0] CFG_A    = 32'h02A7_7520;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, core_run, core_clk_chk;
    logic [3:0]  core_div;
    logic [13:0] core_src;
    logic [17:0] core_noise_ctl;
    logic [31:0] core_health;
    logic [31:0] core_word = '0;
    logic        core_word_vld = 1'b0;
    logic        core_seed_err = 1'b0;
    logic        core_seed_recover = 1'b0;
    logic        core_clk_err = 1'b0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    rng_ctrl_regs u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .core_run(core_run), .core_div(core_div), .core_clk_chk(core_clk_chk),
        .core_src(core_src), .core_noise_ctl(core_noise_ctl),
        .core_health(core_health), .core_word(core_word),
        .core_word_vld(core_word_vld), .core_seed_err(core_seed_err),
        .core_seed_recover(core_seed_recover), .core_clk_err(core_clk_err)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_seed();
        core_seed_err = 1'b1;
        @(negedge clk);
        core_seed_err = 1'b0;
    endtask

    function automatic logic [13:0] src_of(input logic [31:0] w);
        return {w[25:20], w[15:13], w[12], w[11:8]};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_cfg, exp_ri, exp_noise, exp_health, d, r;
        r = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rchk("R1 ctl", A_CTL, 32'h0);
        rchk("R1 stat", A_STAT, 32'h0);
        rchk("R1 noise", A_NOISE, 32'h0);
        rchk("R1 health", A_HEALTH, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 run", 32'(core_run), 32'h0);
        rchk("R13 version", A_VER, 32'h31);

        // R2 configuration accepted with reload set
        wr(A_CTL, RELOAD | CFG_A | 32'h4);
        rchk("R2 ctl", A_CTL, RELOAD | CFG_A | 32'h4);
        chk("R2 div", 32'(core_div), 32'h7);
        chk("R2 src", 32'(core_src), 32'(src_of(CFG_A)));
        chk("R2 clkchk", 32'(core_clk_chk), 32'h1);
        chk("R5 run low while pending", 32'(core_run), 32'h0);

        // R4 reload cycle length
        wr(A_CTL, 32'hC);
        rchk("R4 busy start", A_CTL, RELOAD | CFG_A | 32'hC);
        repeat (15) @(negedge clk);
        rchk("R4 busy last", A_CTL, RELOAD | CFG_A | 32'hC);
        chk("R5 run low busy", 32'(core_run), 32'h0);
        @(negedge clk);
        rchk("R4 done", A_CTL, CFG_A | 32'hC);
        chk("R5 run back", 32'(core_run), 32'h1);

        // R3 fields ignored without reload; R14 unused bits read 0
        wr(A_CTL, 32'h3D5A_A48C);
        rchk("R3 fields kept", A_CTL, CFG_A | 32'hC);
        chk("R3 div kept", 32'(core_div), 32'h7);

        // R14 undefined offsets
        wr(12'h020, 32'hFFFF_FFFF);
        rchk("R14 undef read", 12'h020, 32'h0);
        rchk("R14 ctl untouched", A_CTL, CFG_A | 32'hC);
        rchk("R14 noise untouched", A_NOISE, 32'h0);
        rchk("R14 health untouched", A_HEALTH, 32'h0);

        // R12 noise and health
        wr(A_NOISE, 32'hFFFF_FFFF);
        rchk("R12 noise width", A_NOISE, 32'h0003_FFFF);
        chk("R12 noise out", 32'(core_noise_ctl), 32'h0003_FFFF);
        wr(A_HEALTH, 32'h1234_9ABC);
        rchk("R12 health", A_HEALTH, 32'h1234_9ABC);
        chk("R12 health out", core_health, 32'h1234_9ABC);

        // R11 data ready and data window
        core_word = 32'hA5A5_0001; core_word_vld = 1'b1;
        rchk("R11 ready", A_STAT, 32'h01);
        rchk("R11 data", A_DATA, 32'hA5A5_0001);
        core_word_vld = 1'b0;
        rchk("R11 not ready", A_STAT, 32'h00);
        rchk("R11 data masked", A_DATA, 32'h0);
        core_word_vld = 1'b1;

        // R6 seed error and auto recovery
        pulse_seed();
        rchk("R6 seed set", A_STAT, 32'h44);
        rchk("R11 data blocked by seed", A_DATA, 32'h0);
        chk("R10 irq on", 32'(irq), 32'h1);
        core_seed_recover = 1'b1; @(negedge clk); core_seed_recover = 1'b0;
        rchk("R6 recover", A_STAT, 32'h41);

        // R9 clear by writing 0
        wr(A_STAT, 32'hFFFF_FFBF);
        rchk("R9 seed flag cleared", A_STAT, 32'h01);
        chk("R10 irq off", 32'(irq), 32'h0);

        // R7 reload clears seed state
        pulse_seed();
        wr(A_CTL, RELOAD | CFG_A | 32'hC);
        wr(A_CTL, 32'hC);
        repeat (16) @(negedge clk);
        rchk("R7 state cleared", A_STAT, 32'h41);
        wr(A_STAT, 32'h0);
        rchk("R9 all zero", A_STAT, 32'h01);
        pulse_seed();
        wr(A_STAT, 32'h0);
        rchk("R9 zero clears state", A_STAT, 32'h01);

        // R8 clock error
        core_clk_err = 1'b1;
        @(negedge clk);
        rchk("R8 clk set", A_STAT, 32'h23);
        chk("R10 irq clk", 32'(irq), 32'h1);
        core_clk_err = 1'b0;
        rchk("R8 clk state follows", A_STAT, 32'h21);
        wr(A_STAT, 32'hFFFF_FFDF);
        rchk("R9 clk flag cleared", A_STAT, 32'h01);
        wr(A_CTL, RELOAD | 32'hC);
        wr(A_CTL, 32'hC);
        repeat (16) @(negedge clk);
        chk("R8 check off", 32'(core_clk_chk), 32'h0);
        core_clk_err = 1'b1;
        @(negedge clk);
        rchk("R8 ignored", A_STAT, 32'h01);
        core_clk_err = 1'b0;

        // R10 enable gating
        wr(A_CTL, 32'h4);
        pulse_seed();
        chk("R10 gated", 32'(irq), 32'h0);
        wr(A_CTL, 32'hC);
        chk("R10 ungated", 32'(irq), 32'h1);
        wr(A_STAT, 32'h0);

        // Random phase: R2, R3, R12
        exp_cfg = 32'h0; exp_ri = 32'hC;
        exp_noise = 32'h3FFFF; exp_health = 32'h1234_9ABC;
        for (int i = 0; i < 300; i++) begin
            d = $urandom;
            case ($urandom % 3)
                0: begin wr(A_NOISE, d); exp_noise = d & 32'h3FFFF; end
                1: begin wr(A_HEALTH, d); exp_health = d; end
                default: begin
                    wr(A_CTL, d);
                    if (d[30]) exp_cfg = d & CFG_MASK;
                    exp_ri = d & 32'hC;
                end
            endcase
            rchk("R12 rand noise", A_NOISE, exp_noise);
            rchk("R12 rand health", A_HEALTH, exp_health);
            rd(A_CTL, r);
            chk("R2 R3 rand ctl", r & ~RELOAD, exp_cfg | exp_ri);
            chk("R2 rand div", 32'(core_div), 32'(exp_cfg[19:16]));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule